// File: doc/BRIEF.md
# Snooping Cache Block State Handler

This block holds the coherence state of a single cache block (valid, writable, dirty) and reacts to snoops observed on the memory-side bus. For each accepted snoop it decides three things. It decides whether the block must announce that it keeps a shared copy. It decides whether it must stop memory from answering and supply the line itself. It decides how the stored state changes. Tag comparison, the data array and bus arbitration sit outside. The block receives a tag-match flag and returns a one-cycle supply strobe at the point where the data array should be read for the response.

A read snoop that does not invalidate demotes the block by clearing only its writable bit. A dirty block therefore stays dirty and becomes owned: dirty but not writable, and still responsible for supplying data. A dirty block answers every read snoop. When the read also invalidates, the block keeps its contents until the supply strobe has fired and drops to invalid in the following cycle. The local side can load a new state through a fill port at any time.

Top module: `snoop_blk_state`

## Requirements
- R1: After reset the stored state is invalid, clean and not writable (state_o = 3'b000, with bit 2 valid, bit 1 writable, bit 0 dirty), and shared_o, inhibit_o, supply_o and busy_o are low.
- R2: An accepted snoop with snp_uncache_i high has no effect. shared_o, inhibit_o and supply_o stay low, and state_o is unchanged.
- R3: An accepted snoop with tag_hit_i low, or one that hits a block whose valid bit is clear, has no effect on the outputs or on the state.
- R4: An accepted hitting read snoop without invalidate raises shared_o for one cycle, in the cycle after acceptance. In that same cycle state_o shows writable cleared, with valid and dirty kept, so a dirty block becomes owned (3'b101).
- R5: inhibit_o pulses for one cycle, in the cycle after acceptance, exactly when the snoop is a hitting read and the block is dirty. A block that is clean, or a snoop that is not a read, never raises inhibit_o or supply_o.
- R6: After a supplying snoop, supply_o is high for exactly one cycle, HIT_LAT cycles after the inhibit_o pulse (default HIT_LAT = 2), and low in the cycles between.
- R7: A hitting invalidating snoop that does not supply clears the state to 3'b000 in the cycle after acceptance, without raising shared_o.
- R8: A hitting read with invalidate on a dirty block does not raise shared_o. The stored state is unchanged up to and including the supply_o cycle, and is 3'b000 in the cycle after it.
- R9: busy_o is high from the cycle after a supplying snoop is accepted through the supply_o cycle. Snoops presented while busy_o is high are not accepted and have no effect.
- R10: A hitting snoop that is neither read nor invalidate leaves the state unchanged and raises no output.
- R11: When fill_en_i coincides with an accepted snoop, the snoop is judged against the state held before the fill, so its shared_o, inhibit_o and supply_o follow the old state. The stored state then takes the fill value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| snp_valid_i | input | 1 | Snoop present this cycle |
| snp_read_i | input | 1 | Snoop requests data |
| snp_inval_i | input | 1 | Snoop invalidates other copies |
| snp_uncache_i | input | 1 | Snoop targets an uncacheable address |
| tag_hit_i | input | 1 | Snoop address matched this block's tag |
| fill_en_i | input | 1 | Load fill_state_i into the block state |
| fill_state_i | input | 3 | State to load: bit 2 valid, bit 1 writable, bit 0 dirty |
| state_o | output | 3 | Current block state, same encoding |
| shared_o | output | 1 | One-cycle pulse: block keeps a shared copy |
| inhibit_o | output | 1 | One-cycle pulse: memory must not respond, this cache supplies |
| supply_o | output | 1 | One-cycle strobe: read the line out for the response now |
| busy_o | output | 1 | A supply is in flight; new snoops are not accepted |

## Verification
Two functions can land in the same cycle. A local fill can meet an accepted snoop, and a new snoop can arrive while a supply is still counting down. The bench raises fill_en_i in the very cycle of a read snoop to a dirty block. It expects shared, inhibit and the later supply strobe from the old dirty state, while state_o already shows the filled value. It also offers an invalidating snoop in the first busy cycle after a supplying read. It judges that snoop by the absence of any pulse and by the owned state surviving past the end of the supply.

// File: rtl/snoop_blk_pkg.sv
package snoop_blk_pkg;

  typedef struct packed {
    logic valid;
    logic writable;
    logic dirty;
  } blk_state_t;

  typedef struct packed {
    logic       hit;
    logic       supply;
    logic       shared;
    logic       inval_now;
    logic       inval_late;
    blk_state_t nxt;
  } snp_act_t;

endpackage

// File: rtl/snoop_decide.sv
module snoop_decide
  import snoop_blk_pkg::*;
(
  input  logic       accept_i,
  input  logic       read_i,
  input  logic       inval_i,
  input  logic       uncache_i,
  input  logic       tag_hit_i,
  input  blk_state_t cur_i,
  output snp_act_t   act_o
);

  always_comb begin
    act_o            = '0;
    act_o.nxt        = cur_i;
    act_o.hit        = accept_i & tag_hit_i & ~uncache_i & cur_i.valid;
    act_o.supply     = act_o.hit & read_i & cur_i.dirty;
    act_o.shared     = act_o.hit & read_i & ~inval_i;
    act_o.inval_now  = act_o.hit & inval_i & ~act_o.supply;
    act_o.inval_late = act_o.hit & inval_i & act_o.supply;
    if (act_o.shared)    act_o.nxt.writable = 1'b0;
    if (act_o.inval_now) act_o.nxt          = '0;
  end

endmodule

// File: rtl/snoop_supply_timer.sv
module snoop_supply_timer #(
  parameter int unsigned HIT_LAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic fire_o
);

  localparam int unsigned CW = $clog2(HIT_LAT + 1);

  logic [CW-1:0] cnt_q;
  logic          fire_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= (cnt_q == CW'(1));
      if (start_i)            cnt_q <= CW'(HIT_LAT);
      else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
    end
  end

  assign busy_o = (cnt_q != '0) | fire_q;
  assign fire_o = fire_q;

endmodule

// File: rtl/snoop_state_reg.sv
module snoop_state_reg
  import snoop_blk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fill_en_i,
  input  blk_state_t fill_state_i,
  input  logic       upd_en_i,
  input  blk_state_t upd_state_i,
  input  logic       late_set_i,
  input  logic       fire_i,
  output blk_state_t state_o
);

  blk_state_t st_q;
  logic       late_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      late_q <= 1'b0;
    end else begin
      // deferred invalidate fires only after the line was read out
      if (fire_i && late_q) begin
        st_q   <= '0;
        late_q <= 1'b0;
      end else begin
        if (late_set_i) late_q <= 1'b1;
        if (fill_en_i)     st_q <= fill_state_i;
        else if (upd_en_i) st_q <= upd_state_i;
      end
    end
  end

  assign state_o = st_q;

endmodule

// File: rtl/snoop_blk_state.sv
module snoop_blk_state
  import snoop_blk_pkg::*;
#(
  parameter int unsigned HIT_LAT = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       snp_valid_i,
  input  logic       snp_read_i,
  input  logic       snp_inval_i,
  input  logic       snp_uncache_i,
  input  logic       tag_hit_i,
  input  logic       fill_en_i,
  input  logic [2:0] fill_state_i,
  output logic [2:0] state_o,
  output logic       shared_o,
  output logic       inhibit_o,
  output logic       supply_o,
  output logic       busy_o
);

  blk_state_t cur_st;
  snp_act_t   act;
  logic       accept;
  logic       busy;
  logic       fire;
  logic       shared_q;
  logic       inhibit_q;

  assign accept = snp_valid_i & ~busy;

  snoop_decide u_decide (
    .accept_i  (accept),
    .read_i    (snp_read_i),
    .inval_i   (snp_inval_i),
    .uncache_i (snp_uncache_i),
    .tag_hit_i (tag_hit_i),
    .cur_i     (cur_st),
    .act_o     (act)
  );

  snoop_supply_timer #(.HIT_LAT(HIT_LAT)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (act.supply),
    .busy_o  (busy),
    .fire_o  (fire)
  );

  snoop_state_reg u_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fill_en_i    (fill_en_i),
    .fill_state_i (blk_state_t'(fill_state_i)),
    .upd_en_i     (act.shared | act.inval_now),
    .upd_state_i  (act.nxt),
    .late_set_i   (act.inval_late),
    .fire_i       (fire),
    .state_o      (cur_st)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shared_q  <= 1'b0;
      inhibit_q <= 1'b0;
    end else begin
      shared_q  <= act.shared;
      inhibit_q <= act.supply;
    end
  end

  assign state_o   = cur_st;
  assign shared_o  = shared_q;
  assign inhibit_o = inhibit_q;
  assign supply_o  = fire;
  assign busy_o    = busy;

endmodule

// File: rtl/snoop_blk_state_chk.sv
module snoop_blk_state_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       snp_valid_i,
  input logic       snp_read_i,
  input logic       snp_inval_i,
  input logic       snp_uncache_i,
  input logic       tag_hit_i,
  input logic       fill_en_i,
  input logic [2:0] fill_state_i,
  input logic [2:0] state_o,
  input logic       shared_o,
  input logic       inhibit_o,
  input logic       supply_o,
  input logic       busy_o
);

  p_uncache_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i && snp_uncache_i && !busy_o && !fill_en_i
    |=> !shared_o && !inhibit_o && $stable(state_o));

  p_shared_demotes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shared_o && !$past(fill_en_i)
    |-> !state_o[1] && state_o[2] && (state_o[0] == $past(state_o[0])));

  p_inhibit_needs_dirty_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_o |-> $past(state_o[0]) && $past(snp_read_i));

  p_supply_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_o |=> !supply_o);

  p_no_shared_on_inval_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shared_o |-> !$past(snp_inval_i));

  p_busy_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !shared_o && !inhibit_o);

endmodule

bind snoop_blk_state snoop_blk_state_chk chk_i (.*);

// File: tb/snoop_blk_state_tb_top.sv
module snoop_blk_state_tb_top;

  localparam int unsigned LAT = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       v = 0, rd = 0, inv = 0, unc = 0, hit = 0, fen = 0;
  logic [2:0] fst = '0;
  logic [2:0] st;
  logic       sh, inh, sup, bsy;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  snoop_blk_state #(.HIT_LAT(LAT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .snp_valid_i(v), .snp_read_i(rd),
    .snp_inval_i(inv), .snp_uncache_i(unc), .tag_hit_i(hit),
    .fill_en_i(fen), .fill_state_i(fst), .state_o(st), .shared_o(sh),
    .inhibit_o(inh), .supply_o(sup), .busy_o(bsy)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] s);
    @(negedge clk); fen = 1; fst = s;
    @(negedge clk); fen = 0;
  endtask

  // drives one snoop cycle, returns in the cycle after acceptance
  task automatic snoop(input logic r, input logic i, input logic u, input logic h);
    @(negedge clk); v = 1; rd = r; inv = i; unc = u; hit = h;
    @(negedge clk); v = 0; rd = 0; inv = 0; unc = 0; hit = 0;
  endtask

  task automatic expect_quiet(input string req, input logic [2:0] s);
    chk(req, sh, 0); chk(req, inh, 0); chk(req, int'(st), int'(s));
    for (int k = 0; k < LAT + 1; k++) begin
      @(negedge clk); chk(req, sup, 0); chk(req, int'(st), int'(s));
    end
  endtask

  task automatic t_reset;
    chk("R1", int'(st), 0); chk("R1", sh, 0); chk("R1", inh, 0);
    chk("R1", sup, 0); chk("R1", bsy, 0);
  endtask

  task automatic t_uncache;
    load(3'b111); snoop(1, 0, 1, 1); expect_quiet("R2", 3'b111);
  endtask

  task automatic t_miss;
    load(3'b111); snoop(1, 0, 0, 0); expect_quiet("R3", 3'b111);
    load(3'b011); snoop(1, 1, 0, 1); expect_quiet("R3", 3'b011);
  endtask

  task automatic t_shared_clean;
    load(3'b110); snoop(1, 0, 0, 1);
    chk("R4", sh, 1); chk("R4", int'(st), 3'b100); chk("R5", inh, 0);
    @(negedge clk); chk("R4", sh, 0);
    for (int k = 0; k < LAT; k++) begin @(negedge clk); chk("R5", sup, 0); end
  endtask

  task automatic supply_wait(input string req);
    for (int k = 1; k < LAT; k++) begin
      @(negedge clk); chk(req, sup, 0); chk("R9", bsy, 1);
    end
    @(negedge clk); chk(req, sup, 1); chk("R9", bsy, 1);
  endtask

  task automatic t_owned;
    load(3'b111); snoop(1, 0, 0, 1);
    chk("R4", sh, 1); chk("R5", inh, 1); chk("R4", int'(st), 3'b101); chk("R9", bsy, 1);
    supply_wait("R6");
    @(negedge clk); chk("R6", sup, 0); chk("R9", bsy, 0); chk("R4", int'(st), 3'b101);
    snoop(1, 0, 0, 1);
    chk("R4", sh, 1); chk("R5", inh, 1); chk("R4", int'(st), 3'b101);
    supply_wait("R6");
    @(negedge clk);
  endtask

  task automatic t_inval_clean;
    load(3'b110); snoop(1, 1, 0, 1);
    chk("R7", sh, 0); chk("R5", inh, 0); chk("R7", int'(st), 0);
    load(3'b101); snoop(0, 1, 0, 1);
    chk("R7", sh, 0); chk("R5", inh, 0); chk("R7", int'(st), 0);
    for (int k = 0; k < LAT; k++) begin @(negedge clk); chk("R5", sup, 0); end
  endtask

  task automatic t_inval_dirty;
    load(3'b111); snoop(1, 1, 0, 1);
    chk("R8", sh, 0); chk("R5", inh, 1); chk("R8", int'(st), 3'b111);
    for (int k = 1; k < LAT; k++) begin
      @(negedge clk); chk("R8", int'(st), 3'b111); chk("R6", sup, 0);
    end
    @(negedge clk); chk("R6", sup, 1); chk("R8", int'(st), 3'b111);
    @(negedge clk); chk("R8", int'(st), 0); chk("R9", bsy, 0);
  endtask

  task automatic t_write_snoop;
    load(3'b111); snoop(0, 0, 0, 1); expect_quiet("R10", 3'b111);
  endtask

  task automatic t_busy;
    load(3'b111); snoop(1, 0, 0, 1);
    chk("R9", bsy, 1);
    v = 1; rd = 1; inv = 1; hit = 1;
    @(negedge clk); v = 0; rd = 0; inv = 0; hit = 0;
    chk("R9", sh, 0); chk("R9", inh, 0);
    for (int k = 0; k < LAT + 1; k++) @(negedge clk);
    chk("R9", int'(st), 3'b101); chk("R9", bsy, 0);
  endtask

  task automatic t_fill_same;
    load(3'b111);
    @(negedge clk); v = 1; rd = 1; hit = 1; fen = 1; fst = 3'b110;
    @(negedge clk); v = 0; rd = 0; hit = 0; fen = 0;
    chk("R11", sh, 1); chk("R11", inh, 1); chk("R11", int'(st), 3'b110);
    supply_wait("R11");
    @(negedge clk); chk("R11", int'(st), 3'b110);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_uncache();
    t_miss();
    t_shared_clean();
    t_owned();
    t_inval_clean();
    t_inval_dirty();
    t_write_snoop();
    t_busy();
    t_fill_same();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule